// File: doc/BRIEF.md
# Two-Phase Bankset Lookup Sequencer

This block finds which bank, if any, holds a requested cache line. The line's address selects one bankset. That bankset has sixteen ways, and each way lives in a different bank. Eight of those banks are local banks, one placed beside each core. The other eight are central banks. The sequencer does not probe all sixteen banks at once. It searches in two multicast rounds.

The first round probes the bank beside the requesting core and every central bank, nine probes in total. The second round is issued only if all nine of those miss, and it probes the other seven local banks. When all sixteen banks miss, the sequencer reports that the line must be fetched from off-chip memory. Bank answers return after varying delays. A round closes at the first hit, or after every bank it probed has answered. Only one request is handled at a time.

The controller is a single state machine with six states:

- **IDLE**: waiting for a request.
- **P1_SEND**: one cycle that drives the first-round probe vector.
- **P1_WAIT**: collects first-round answers.
- **P2_SEND**: one cycle that drives the second-round probe vector.
- **P2_WAIT**: collects second-round answers.
- **DONE**: a one-cycle result strobe.

The transitions are:

- IDLE→P1_SEND on an accepted request.
- P1_SEND→P1_WAIT and P2_SEND→P2_WAIT unconditionally.
- P1_WAIT→DONE on a hit.
- P1_WAIT→P2_SEND once all nine banks have answered with no hit.
- P2_WAIT→DONE on a hit, or once all seven banks have answered (the off-chip case).
- DONE→IDLE.

Top module: `msearch_seq`

## Requirements
- R1: After reset, `busy`, `probe_vld` and `res_valid` are all low.
- R2: Banks are numbered as follows: index i (0..N_CORE-1) is the local bank beside core i, and indices N_CORE..2*N_CORE-1 are the central banks. One cycle after a request is accepted, `probe_vld` pulses for exactly one cycle with bit `req_core` and all central bits set.
- R3: `probe_set` equals `req_addr[LINE_OFF+SET_W-1:LINE_OFF]` of the accepted request. It holds that value from the first-round probe cycle until the result cycle.
- R4: In the first round, the first hit response from a probed bank ends the search. `res_valid` rises the cycle after that response, with `res_hit`=1 and `res_bank` set to that bank. If several probed banks hit in the same cycle, the lowest index wins. No second round is issued.
- R5: If the first round has no hit, the second round is issued only after all nine probed banks have answered. It comes one cycle after the last answer, as a one-cycle pulse on the seven local banks other than `req_core`.
- R6: A second-round hit is reported the cycle after its response, with `res_hit`=1 and the same lowest-index tie rule.
- R7: If all sixteen banks miss, `res_valid` rises one cycle after the last second-round answer, with `res_hit`=0, meaning the line must come from off-chip memory.
- R8: A response from a bank that is not awaited in the current round is ignored. This covers a bank that was not probed, a bank that has already answered, and any response arriving after the round has closed.
- R9: `busy` is high from the first probe cycle through the result cycle. A `req_valid` seen while busy is ignored, and the result still refers to the first request.
- R10: `res_valid` is a single-cycle pulse, and `res_addr` carries the accepted request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W | Line address |
| req_core | input | CORE_W | Requesting core index |
| busy | output | 1 | A search is in progress |
| probe_vld | output | 2*N_CORE | One-cycle per-bank lookup pulses |
| probe_set | output | SET_W | Bankset index sent with the probes |
| rsp_vld | input | 2*N_CORE | Per-bank answer strobe |
| rsp_hit | input | 2*N_CORE | Per-bank hit flag, valid with `rsp_vld` |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | 1: line found; 0: forward to off-chip memory |
| res_bank | output | BANK_W | Bank that hit |
| res_addr | output | ADDR_W | Address of the finished request |

## Verification
The embedded assertions check several properties on every cycle:

- every probe vector is a single-cycle pulse of the right size for its round;
- the bankset index is stable while busy;
- the result strobe lasts one cycle;
- a busy sequencer never re-enters the first round;
- a reported hit always comes from a bank that belongs to the current round.

The bench scenarios cover what depends on bank timing. They check which bank wins when answers race or tie, the exact cycle of the result and of the second round, and that spurious or late answers change nothing. They also check that a request made while busy leaves the result untouched.

// File: rtl/msearch_pkg.sv
package msearch_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_P1_SEND,
        S_P1_WAIT,
        S_P2_SEND,
        S_P2_WAIT,
        S_DONE
    } srch_state_e;

endpackage

// File: rtl/msearch_targets.sv
module msearch_targets #(
    parameter int N_CORE = 8,
    localparam int N_BANK = 2 * N_CORE,
    localparam int CORE_W = $clog2(N_CORE)
) (
    input  logic [CORE_W-1:0] core,
    output logic [N_BANK-1:0] mask_first,
    output logic [N_BANK-1:0] mask_second
);

    // Local bank g sits beside core g; central banks follow the local ones.
    for (genvar g = 0; g < N_CORE; g++) begin : g_bank
        assign mask_first[g]           = (core == CORE_W'(g));
        assign mask_second[g]          = (core != CORE_W'(g));
        assign mask_first[N_CORE + g]  = 1'b1;
        assign mask_second[N_CORE + g] = 1'b0;
    end

endmodule

// File: rtl/msearch_tracker.sv
module msearch_tracker #(
    parameter int N_BANK = 16,
    localparam int BANK_W = $clog2(N_BANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_BANK-1:0] load_mask,
    input  logic              clear,
    input  logic [N_BANK-1:0] rsp_vld,
    input  logic [N_BANK-1:0] rsp_hit,
    output logic [N_BANK-1:0] pending,
    output logic              hit_any,
    output logic [BANK_W-1:0] hit_idx,
    output logic              drained
);

    logic [N_BANK-1:0] live_hits;

    // Only banks still awaited in this round may contribute.
    assign live_hits = pending & rsp_vld & rsp_hit;
    assign hit_any   = |live_hits;
    assign drained   = (pending != '0) && ((pending & ~rsp_vld) == '0);

    // Lowest index wins among same-cycle hits.
    always_comb begin
        hit_idx = '0;
        for (int i = N_BANK - 1; i >= 0; i--) begin
            if (live_hits[i]) hit_idx = BANK_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (load) begin
            pending <= load_mask;
        end else if (clear) begin
            pending <= '0;
        end else begin
            pending <= pending & ~rsp_vld;
        end
    end

    // R8: outside a load, the awaited set never gains members.
    p_pending_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pending & ~$past(pending)) == '0));

endmodule

// File: rtl/msearch_seq.sv
module msearch_seq
    import msearch_pkg::*;
#(
    parameter int N_CORE   = 8,
    parameter int ADDR_W   = 40,
    parameter int LINE_OFF = 6,
    parameter int SET_W    = 4,
    localparam int N_BANK = 2 * N_CORE,
    localparam int BANK_W = $clog2(N_BANK),
    localparam int CORE_W = $clog2(N_CORE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] req_core,
    output logic              busy,
    output logic [N_BANK-1:0] probe_vld,
    output logic [SET_W-1:0]  probe_set,
    input  logic [N_BANK-1:0] rsp_vld,
    input  logic [N_BANK-1:0] rsp_hit,
    output logic              res_valid,
    output logic              res_hit,
    output logic [BANK_W-1:0] res_bank,
    output logic [ADDR_W-1:0] res_addr
);

    srch_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [CORE_W-1:0] core_q;
    logic              hit_q;
    logic [BANK_W-1:0] bank_q;

    logic [N_BANK-1:0] mask_first, mask_second;
    logic [N_BANK-1:0] pending;
    logic              hit_any, drained;
    logic [BANK_W-1:0] hit_idx;
    logic              trk_load, trk_clear;
    logic [N_BANK-1:0] trk_mask;
    logic              in_wait;

    msearch_targets #(.N_CORE(N_CORE)) u_targets (
        .core        (core_q),
        .mask_first  (mask_first),
        .mask_second (mask_second)
    );

    msearch_tracker #(.N_BANK(N_BANK)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_mask (trk_mask),
        .clear     (trk_clear),
        .rsp_vld   (rsp_vld),
        .rsp_hit   (rsp_hit),
        .pending   (pending),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .drained   (drained)
    );

    assign in_wait = (state_q == S_P1_WAIT) || (state_q == S_P2_WAIT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_P1_SEND;
            S_P1_SEND: state_d = S_P1_WAIT;
            S_P1_WAIT: begin
                if (hit_any)      state_d = S_DONE;
                else if (drained) state_d = S_P2_SEND;
            end
            S_P2_SEND: state_d = S_P2_WAIT;
            S_P2_WAIT: begin
                if (hit_any || drained) state_d = S_DONE;
            end
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and tracker control
    always_comb begin
        busy      = 1'b1;
        probe_vld = '0;
        res_valid = 1'b0;
        trk_load  = 1'b0;
        trk_mask  = mask_first;
        trk_clear = 1'b0;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_P1_SEND: begin
                probe_vld = mask_first;
                trk_load  = 1'b1;
                trk_mask  = mask_first;
            end
            S_P1_WAIT: trk_clear = hit_any;
            S_P2_SEND: begin
                probe_vld = mask_second;
                trk_load  = 1'b1;
                trk_mask  = mask_second;
            end
            S_P2_WAIT: trk_clear = hit_any;
            S_DONE:    res_valid = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // Request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            core_q <= '0;
            hit_q  <= 1'b0;
            bank_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                addr_q <= req_addr;
                core_q <= req_core;
                hit_q  <= 1'b0;
                bank_q <= '0;
            end
            if (in_wait && hit_any) begin
                hit_q  <= 1'b1;
                bank_q <= hit_idx;
            end
        end
    end

    assign probe_set = addr_q[LINE_OFF +: SET_W];
    assign res_hit   = hit_q;
    assign res_bank  = bank_q;
    assign res_addr  = addr_q;

    // R2: probe vectors are single-cycle pulses.
    p_probe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_vld != '0) |=> (probe_vld == '0));

    // R2: the first round reaches the core's own bank plus every central bank.
    p_first_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_P1_SEND) |-> ($countones(probe_vld) == N_CORE + 1));

    // R5: the second round reaches the remaining local banks only.
    p_second_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_P2_SEND) |-> ($countones(probe_vld) == N_CORE - 1));

    // R4: a first-round hit comes from the core's own bank or a central one.
    p_first_hit_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_P1_WAIT && hit_any) |->
            (hit_idx >= BANK_W'(N_CORE) || hit_idx == BANK_W'(core_q)));

    // R6: a second-round hit comes from another core's local bank.
    p_second_hit_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_P2_WAIT && hit_any) |->
            (hit_idx < BANK_W'(N_CORE) && hit_idx != BANK_W'(core_q)));

    // R3: the bankset index holds while a search runs.
    p_set_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(probe_set));

    // R10: the result strobe lasts one cycle.
    p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9: no new search starts while one is in progress.
    p_no_reaccept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_q != S_P1_SEND));

endmodule

// File: tb/sim_msearch_seq.sv
module sim_msearch_seq;

    localparam int N_CORE   = 8;
    localparam int ADDR_W   = 40;
    localparam int LINE_OFF = 6;
    localparam int SET_W    = 4;
    localparam int N_BANK   = 2 * N_CORE;
    localparam int BANK_W   = $clog2(N_BANK);
    localparam int CORE_W   = $clog2(N_CORE);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CORE_W-1:0] req_core = '0;
    logic              busy;
    logic [N_BANK-1:0] probe_vld;
    logic [SET_W-1:0]  probe_set;
    logic [N_BANK-1:0] rsp_vld, rsp_hit;
    logic              res_valid, res_hit;
    logic [BANK_W-1:0] res_bank;
    logic [ADDR_W-1:0] res_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // Bank models
    int                cnt [N_BANK];
    int                lat [N_BANK];
    logic [N_BANK-1:0] hit_map  = '0;
    logic [N_BANK-1:0] spur_vld = '0;

    always #4 clk = ~clk;

    initial begin
        for (int b = 0; b < N_BANK; b++) begin
            cnt[b] = 0;
            lat[b] = 1;
        end
    end

    always @(posedge clk) begin
        for (int b = 0; b < N_BANK; b++) begin
            if (probe_vld[b])     cnt[b] <= lat[b];
            else if (cnt[b] != 0) cnt[b] <= cnt[b] - 1;
        end
    end

    always_comb begin
        for (int b = 0; b < N_BANK; b++) begin
            rsp_vld[b] = (cnt[b] == 1) | spur_vld[b];
            rsp_hit[b] = hit_map[b] | spur_vld[b];
        end
    end

    msearch_seq #(
        .N_CORE(N_CORE), .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .SET_W(SET_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_core(req_core), .busy(busy), .probe_vld(probe_vld),
        .probe_set(probe_set), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
        .res_valid(res_valid), .res_hit(res_hit), .res_bank(res_bank),
        .res_addr(res_addr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one request and checks it against the arithmetic model.
    // mode 0: plain; 1: second request while busy; 2: spurious answer on an unprobed bank
    task automatic run_req(input logic [ADDR_W-1:0] addr, input int core, input int mode);
        logic [N_BANK-1:0] m1, m2, p1, p2;
        int  best, bl, m1max, m2max, cyc, exp_cyc, sb;
        bit  exp_hit;
        int  exp_bank;
        string tag;
        m1 = '0; m2 = '0;
        for (int b = 0; b < N_CORE; b++) begin
            if (b == core) m1[b] = 1'b1; else m2[b] = 1'b1;
            m1[N_CORE + b] = 1'b1;
        end
        best = -1; bl = 1000; m1max = 0;
        for (int b = 0; b < N_BANK; b++) if (m1[b]) begin
            if (lat[b] > m1max) m1max = lat[b];
            if (hit_map[b] && lat[b] < bl) begin bl = lat[b]; best = b; end
        end
        if (best >= 0) begin
            exp_hit = 1; exp_bank = best; exp_cyc = bl + 1; tag = "R4";
        end else begin
            m2max = 0;
            for (int b = 0; b < N_BANK; b++) if (m2[b]) begin
                if (lat[b] > m2max) m2max = lat[b];
                if (hit_map[b] && lat[b] < bl) begin bl = lat[b]; best = b; end
            end
            if (best >= 0) begin
                exp_hit = 1; exp_bank = best; exp_cyc = m1max + 2 + bl; tag = "R6";
            end else begin
                exp_hit = 0; exp_bank = 0; exp_cyc = m1max + 2 + m2max; tag = "R7";
            end
        end
        sb = (core + 1) % N_CORE;

        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_core = CORE_W'(core);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy at first probe", busy, 1);
        cyc = 0; p1 = '0; p2 = '0;
        while (!res_valid && cyc < 100) begin
            if (probe_vld != '0) begin
                if (p1 == '0) p1 = probe_vld; else p2 = probe_vld;
                check(probe_set == SET_W'(addr >> LINE_OFF), "R3 probe_set", probe_set,
                      (addr >> LINE_OFF) % (1 << SET_W));
            end
            if (mode == 1) begin
                req_valid = (cyc == 2);
                req_addr  = ~addr;
                req_core  = CORE_W'(sb);
            end
            if (mode == 2) spur_vld = (cyc == 1 || cyc == 2) ? (N_BANK'(1) << sb) : '0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0; spur_vld = '0;
        check(cyc == exp_cyc, {tag, " result cycle"}, cyc, exp_cyc);
        check(res_hit == exp_hit, {tag, " res_hit"}, res_hit, exp_hit);
        if (exp_hit) check(res_bank == BANK_W'(exp_bank), {tag, " res_bank"}, res_bank, exp_bank);
        check(res_addr == addr, "R10 res_addr", res_addr, addr);
        check(p1 == m1, "R2 first-round mask", p1, m1);
        check(p2 == ((tag == "R4") ? '0 : m2), "R5 second-round mask", p2, (tag == "R4") ? 0 : m2);
        @(negedge clk);
        check(!res_valid && !busy, "R10 R9 single-cycle result then idle", {res_valid, busy}, 0);
        // Late answers must not produce any activity (R8).
        for (int i = 0; i < 8; i++) begin
            if (res_valid || busy || probe_vld != '0) begin
                check(0, "R8 activity from late answer", {res_valid, busy}, 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic set_lat(input int core, input int iter);
        for (int b = 0; b < N_BANK; b++) lat[b] = 1 + ((b * 5 + core * 3 + iter) % 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && probe_vld == '0 && !res_valid, "R1 reset state",
              {busy, res_valid, |probe_vld}, 0);

        for (int core = 0; core < N_CORE; core++) begin
            for (int pat = 0; pat < N_BANK + 3; pat++) begin
                set_lat(core, pat);
                if (pat < N_BANK)           hit_map = N_BANK'(1) << pat;
                else if (pat == N_BANK)     hit_map = '0;
                else if (pat == N_BANK + 1) hit_map = '1;
                else hit_map = (N_BANK'(1) << core) | (N_BANK'(1) << (N_CORE + (core + 3) % N_CORE));
                run_req(ADDR_W'(core * 1000003 + pat * 7919 * 64 + pat * 64), core, 0);
            end
        end

        // R8: spurious hit on an unprobed local bank during the first round.
        for (int b = 0; b < N_BANK; b++) lat[b] = 4;
        hit_map = N_BANK'(1) << N_CORE;
        run_req(ADDR_W'(40'h12_3456_7890), 2, 2);

        // R4 tie: two central banks hit in the same cycle, lowest index wins.
        hit_map = (N_BANK'(1) << (N_CORE + 5)) | (N_BANK'(1) << (N_CORE + 2));
        run_req(ADDR_W'(40'h0a_0000_0cc0), 6, 0);

        // R9: a request issued while busy is ignored.
        set_lat(3, 1);
        hit_map = N_BANK'(1) << 5;
        run_req(ADDR_W'(40'h33_0000_1240), 3, 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule